// File: doc/BRIEF.md
# Binary-Field Affine Point Adder/Doubler

This unit carries out a single group operation on an elliptic curve of the form y^2 + xy = x^3 + ax^2 + b over the small binary field GF(2^8), with elements reduced by x^8 + x^4 + x^3 + x + 1 and field addition being bitwise XOR. A caller presents two affine points, each with its own "point at infinity" flag, the curve coefficient a and an operation select, then pulses `start`. Some time later the unit pulses `done` and presents the result point together with an infinity flag.

Inside, a bit-serial multiplier (one shift-and-reduce step per cycle) is sequenced by a small controller. A separate inverter computes z^(2^m - 2) by alternating squaring and multiplication on its own serial multiplier. Every non-trivial operation needs exactly one inversion, and that inversion dominates the latency. Identity operands, doubling a point with x = 0, and adding a point to its negative are resolved in the cycle after `start` without any arithmetic.

Top module: `ecc_affine_unit`

## Requirements
- R1: With `op` = 0 (add), both points finite and x1 != x2, the result is lambda = (y1 ^ y2) / (x1 ^ x2), xR = lambda^2 ^ lambda ^ x1 ^ x2 ^ a, yR = lambda*(x1 ^ xR) ^ xR ^ y1. Products are in GF(2^8) modulo x^8 + x^4 + x^3 + x + 1 (0x11B), and "^" is XOR.
- R2: With `op` = 1 (double), P finite and x1 != 0, the result is lambda = x1 ^ y1/x1, xR = lambda^2 ^ lambda ^ a, yR = x1^2 ^ (lambda ^ 1)*xR.
- R3: An add of two finite points with equal x != 0 and equal y gives the same result as doubling P.
- R4: An add of two finite points with equal x but different y, or with Q equal to the negative (x1, x1 ^ y1) of P, gives the point at infinity.
- R5: An add where P is at infinity returns Q unchanged. An add where Q is at infinity returns P. An add where both are at infinity returns infinity.
- R6: Doubling a point at infinity, or a point whose x is 0, gives the point at infinity.
- R7: A result at infinity is reported as `r_inf` = 1 with `r_x` = `r_y` = 0. After reset, `done` = 0 and the outputs hold this infinity encoding.
- R8: `done` is high for exactly one cycle per operation. `r_x`, `r_y` and `r_inf` do not change except in the cycle in which `done` is high.
- R9: A `start` pulse that arrives while an operation is in progress is ignored. The result delivered is that of the operation already running, and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 1 | 0 = add P+Q, 1 = double P |
| p_x | input | 8 | x coordinate of P |
| p_y | input | 8 | y coordinate of P |
| p_inf | input | 1 | P is the point at infinity |
| q_x | input | 8 | x coordinate of Q |
| q_y | input | 8 | y coordinate of Q |
| q_inf | input | 1 | Q is the point at infinity |
| a_coef | input | 8 | Curve coefficient a |
| r_x | output | 8 | x coordinate of the result |
| r_y | output | 8 | y coordinate of the result |
| r_inf | output | 1 | Result is the point at infinity |
| done | output | 1 | One-cycle completion pulse |

## Verification
Random coordinate pairs with distinct x exercise the chord path. They separate a faulty inversion or reduction polynomial from a correct one, because every wrong field product propagates into both output coordinates. Random single points under `op` = 1 cover the tangent path, including the lambda ^ 1 and x1^2 terms that only doubling uses. Directed pairs pin down the branch decisions: a point with itself, with its negative, with a same-x point of a third y, with x = 0, and with infinity in either operand slot. A second `start` issued mid-operation, and a long idle stretch after `done`, show whether the sequencer can be retriggered and whether the outputs drift.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    parameter int unsigned FW = 8;
    parameter logic [FW-1:0] RED = 8'h1B;

    typedef logic [FW-1:0] fe_t;

    typedef enum logic { OP_ADD = 1'b0, OP_DBL = 1'b1 } op_e;

    typedef struct packed {
        fe_t  x;
        fe_t  y;
        logic inf;
    } pt_t;

    typedef enum logic [2:0] {
        IV_IDLE, IV_SQ_GO, IV_SQ_W, IV_MU_GO, IV_MU_W
    } inv_st_e;

    typedef enum logic [1:0] {
        T_IDLE, T_INV, T_MGO, T_MW
    } top_st_e;

    localparam pt_t PT_INF = '{x: '0, y: '0, inf: 1'b1};

    function automatic fe_t fe_xtime(fe_t v);
        return {v[FW-2:0], 1'b0} ^ (v[FW-1] ? RED : '0);
    endfunction
endpackage

// File: rtl/ecc_gf_mul.sv
module ecc_gf_mul
    import ecc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  fe_t  opa,
    input  fe_t  opb,
    output fe_t  prod,
    output logic fin
);
    localparam int CW = $clog2(FW + 1);

    logic [CW-1:0] cnt;
    fe_t           ra;
    fe_t           rb;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            ra   <= '0;
            rb   <= '0;
            prod <= '0;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                ra   <= opa;
                rb   <= opb;
                prod <= '0;
                cnt  <= CW'(FW);
            end else if (cnt != '0) begin
                prod <= fe_xtime(prod) ^ (rb[FW-1] ? ra : '0);
                rb   <= rb << 1;
                cnt  <= cnt - 1'b1;
                if (cnt == CW'(1)) fin <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ecc_gf_inv.sv
module ecc_gf_inv
    import ecc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  fe_t  val,
    output fe_t  res,
    output logic fin,
    output logic err
);
    localparam int RW = $clog2(FW);

    inv_st_e       st;
    fe_t           sq;
    fe_t           acc;
    logic [RW-1:0] rnd;
    logic          m_go;
    fe_t           m_a;
    fe_t           m_p;
    logic          m_fin;

    assign m_go = (st == IV_SQ_GO) || (st == IV_MU_GO);
    assign m_a  = (st == IV_MU_GO) ? acc : sq;

    ecc_gf_mul u_mul (
        .clk (clk),
        .rst (rst),
        .go  (m_go),
        .opa (m_a),
        .opb (sq),
        .prod(m_p),
        .fin (m_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= IV_IDLE;
            sq  <= '0;
            acc <= '0;
            rnd <= '0;
            res <= '0;
            fin <= 1'b0;
            err <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (st)
                IV_IDLE: if (go) begin
                    if (val == '0) begin
                        res <= '0;
                        err <= 1'b1;
                        fin <= 1'b1;
                    end else begin
                        sq  <= val;
                        acc <= fe_t'(1);
                        rnd <= RW'(FW - 1);
                        err <= 1'b0;
                        st  <= IV_SQ_GO;
                    end
                end
                IV_SQ_GO: st <= IV_SQ_W;
                IV_SQ_W: if (m_fin) begin
                    sq <= m_p;
                    st <= IV_MU_GO;
                end
                IV_MU_GO: st <= IV_MU_W;
                IV_MU_W: if (m_fin) begin
                    acc <= m_p;
                    if (rnd == RW'(1)) begin
                        res <= m_p;
                        fin <= 1'b1;
                        st  <= IV_IDLE;
                    end else begin
                        rnd <= rnd - 1'b1;
                        st  <= IV_SQ_GO;
                    end
                end
                default: st <= IV_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ecc_affine_unit.sv
module ecc_affine_unit
    import ecc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          op,
    input  logic [FW-1:0] p_x,
    input  logic [FW-1:0] p_y,
    input  logic          p_inf,
    input  logic [FW-1:0] q_x,
    input  logic [FW-1:0] q_y,
    input  logic          q_inf,
    input  logic [FW-1:0] a_coef,
    output logic [FW-1:0] r_x,
    output logic [FW-1:0] r_y,
    output logic          r_inf,
    output logic          done
);
    top_st_e    st;
    logic       busy;
    fe_t        x1, y1, x2, y2, ac;
    logic       dbl;
    logic [1:0] k;
    fe_t        lam, xr, tmp, dinv;

    logic triv, use_dbl;
    pt_t  tp;

    logic inv_go, inv_fin, inv_err;
    fe_t  inv_val, inv_res;
    logic m_go, m_fin;
    fe_t  m_a, m_b, m_p;

    assign busy = (st != T_IDLE);

    // Case split taken on the start cycle
    always_comb begin
        triv    = 1'b0;
        use_dbl = 1'b0;
        tp      = PT_INF;
        if (op_e'(op) == OP_DBL) begin
            if (p_inf || p_x == '0) triv = 1'b1;
            else                    use_dbl = 1'b1;
        end else if (p_inf) begin
            triv = 1'b1;
            if (!q_inf) tp = '{x: q_x, y: q_y, inf: 1'b0};
        end else if (q_inf) begin
            triv = 1'b1;
            tp   = '{x: p_x, y: p_y, inf: 1'b0};
        end else if (p_x == q_x) begin
            if (p_y == q_y && p_x != '0) use_dbl = 1'b1;
            else                         triv = 1'b1;
        end
    end

    assign inv_go  = (st == T_IDLE) && start && !triv;
    assign inv_val = use_dbl ? p_x : (p_x ^ q_x);

    ecc_gf_inv u_inv (
        .clk(clk),
        .rst(rst),
        .go (inv_go),
        .val(inv_val),
        .res(inv_res),
        .fin(inv_fin),
        .err(inv_err)
    );

    // Operand selection for each multiply step
    always_comb begin
        m_a = lam;
        m_b = lam;
        if (dbl) begin
            case (k)
                2'd0:    begin m_a = y1;               m_b = dinv; end
                2'd1:    begin m_a = lam;              m_b = lam;  end
                2'd2:    begin m_a = x1;               m_b = x1;   end
                default: begin m_a = lam ^ fe_t'(1);   m_b = xr;   end
            endcase
        end else begin
            case (k)
                2'd0:    begin m_a = y1 ^ y2; m_b = dinv;    end
                2'd1:    begin m_a = lam;     m_b = lam;     end
                default: begin m_a = lam;     m_b = x1 ^ xr; end
            endcase
        end
    end

    assign m_go = (st == T_MGO);

    ecc_gf_mul u_mul (
        .clk (clk),
        .rst (rst),
        .go  (m_go),
        .opa (m_a),
        .opb (m_b),
        .prod(m_p),
        .fin (m_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= T_IDLE;
            x1    <= '0; y1 <= '0; x2 <= '0; y2 <= '0; ac <= '0;
            dbl   <= 1'b0;
            k     <= '0;
            lam   <= '0; xr <= '0; tmp <= '0; dinv <= '0;
            r_x   <= '0;
            r_y   <= '0;
            r_inf <= 1'b1;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                T_IDLE: if (start) begin
                    if (triv) begin
                        r_x   <= tp.x;
                        r_y   <= tp.y;
                        r_inf <= tp.inf;
                        done  <= 1'b1;
                    end else begin
                        x1  <= p_x; y1 <= p_y;
                        x2  <= q_x; y2 <= q_y;
                        ac  <= a_coef;
                        dbl <= use_dbl;
                        st  <= T_INV;
                    end
                end
                T_INV: if (inv_fin) begin
                    if (inv_err) begin
                        r_x   <= '0;
                        r_y   <= '0;
                        r_inf <= 1'b1;
                        done  <= 1'b1;
                        st    <= T_IDLE;
                    end else begin
                        dinv <= inv_res;
                        k    <= '0;
                        st   <= T_MGO;
                    end
                end
                T_MGO: st <= T_MW;
                T_MW: if (m_fin) begin
                    st <= T_MGO;
                    k  <= k + 1'b1;
                    if (dbl) begin
                        case (k)
                            2'd0: lam <= x1 ^ m_p;
                            2'd1: xr  <= m_p ^ lam ^ ac;
                            2'd2: tmp <= m_p;
                            default: begin
                                r_x   <= xr;
                                r_y   <= tmp ^ m_p;
                                r_inf <= 1'b0;
                                done  <= 1'b1;
                                st    <= T_IDLE;
                            end
                        endcase
                    end else begin
                        case (k)
                            2'd0: lam <= m_p;
                            2'd1: xr  <= m_p ^ lam ^ x1 ^ x2 ^ ac;
                            default: begin
                                r_x   <= xr;
                                r_y   <= m_p ^ xr ^ y1;
                                r_inf <= 1'b0;
                                done  <= 1'b1;
                                st    <= T_IDLE;
                            end
                        endcase
                    end
                end
                default: st <= T_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ecc_affine_chk.sv
module ecc_affine_chk
    import ecc_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          op,
    input logic [FW-1:0] p_x,
    input logic [FW-1:0] p_y,
    input logic          p_inf,
    input logic [FW-1:0] q_x,
    input logic [FW-1:0] q_y,
    input logic          q_inf,
    input logic [FW-1:0] r_x,
    input logic [FW-1:0] r_y,
    input logic          r_inf,
    input logic          done,
    input logic          busy
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done); // R8

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({r_x, r_y, r_inf})); // R8

    AST_INF_CODE: assert property (@(posedge clk) disable iff (rst)
        r_inf |-> (r_x == '0 && r_y == '0)); // R7

    AST_LEFT_IDENT: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !op && p_inf && !q_inf)
        |=> (done && !r_inf && r_x == $past(q_x) && r_y == $past(q_y))); // R5

    AST_NEG_SUM: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !op && !p_inf && !q_inf && p_x == q_x && q_y == (p_x ^ p_y))
        |=> (done && r_inf)); // R4

    AST_DBL_XZERO: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op && p_x == '0) |=> (done && r_inf)); // R6
endmodule

bind ecc_affine_unit ecc_affine_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .op   (op),
    .p_x  (p_x),
    .p_y  (p_y),
    .p_inf(p_inf),
    .q_x  (q_x),
    .q_y  (q_y),
    .q_inf(q_inf),
    .r_x  (r_x),
    .r_y  (r_y),
    .r_inf(r_inf),
    .done (done),
    .busy (busy)
);

// File: tb/sim_ecc_affine_unit.sv
module sim_ecc_affine_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       op = 1'b0;
    logic [7:0] p_x = '0, p_y = '0, q_x = '0, q_y = '0, a_coef = '0;
    logic       p_inf = 1'b0, q_inf = 1'b0;
    logic [7:0] r_x, r_y;
    logic       r_inf, done;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_affine_unit u0 (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .p_x(p_x), .p_y(p_y), .p_inf(p_inf),
        .q_x(q_x), .q_y(q_y), .q_inf(q_inf),
        .a_coef(a_coef),
        .r_x(r_x), .r_y(r_y), .r_inf(r_inf), .done(done)
    );

    // Reference field arithmetic, LSB-first, independent of the RTL
    function automatic logic [7:0] fmul(logic [7:0] a, logic [7:0] b);
        logic [7:0] r = '0;
        logic [7:0] t = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= t;
            t = t[7] ? ((t << 1) ^ 8'h1B) : (t << 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] finv(logic [7:0] a);
        for (int z = 1; z < 256; z++)
            if (fmul(a, 8'(z)) == 8'h01) return 8'(z);
        return 8'h00;
    endfunction

    // Returns {inf, x, y}
    function automatic logic [16:0] model(logic o, logic [7:0] ax, logic [7:0] ay, logic ai,
                                          logic [7:0] bx, logic [7:0] by, logic bi, logic [7:0] ca);
        logic [7:0] l, xo;
        logic dodbl = 1'b0;
        if (o) begin
            if (ai || ax == 8'h00) return {1'b1, 16'h0000};
            dodbl = 1'b1;
        end else begin
            if (ai) return bi ? {1'b1, 16'h0000} : {1'b0, bx, by};
            if (bi) return {1'b0, ax, ay};
            if (ax == bx) begin
                if (ay == by && ax != 8'h00) dodbl = 1'b1;
                else return {1'b1, 16'h0000};
            end
        end
        if (dodbl) begin
            l  = ax ^ fmul(ay, finv(ax));
            xo = fmul(l, l) ^ l ^ ca;
            return {1'b0, xo, fmul(ax, ax) ^ fmul(l ^ 8'h01, xo)};
        end
        l  = fmul(ay ^ by, finv(ax ^ bx));
        xo = fmul(l, l) ^ l ^ ax ^ bx ^ ca;
        return {1'b0, xo, fmul(l, ax ^ xo) ^ xo ^ ay};
    endfunction

    task automatic check(string tag, logic [16:0] act, logic [16:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic o, logic [7:0] ax, logic [7:0] ay, logic ai,
                         logic [7:0] bx, logic [7:0] by, logic bi, logic [7:0] ca);
        op = o; p_x = ax; p_y = ay; p_inf = ai;
        q_x = bx; q_y = by; q_inf = bi; a_coef = ca;
    endtask

    // Runs one operation; inputs already driven. Returns {inf,x,y} at done.
    task automatic run(string tag, output logic [16:0] res);
        int n = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (!done) check({tag, " timeout"}, 17'h0, 17'h1);
        res = {r_inf, r_x, r_y};
        @(negedge clk);
        check({"R8 single done ", tag}, {16'h0, done}, 17'h0);
    endtask

    task automatic op_check(string tag, logic o, logic [7:0] ax, logic [7:0] ay, logic ai,
                            logic [7:0] bx, logic [7:0] by, logic bi, logic [7:0] ca);
        logic [16:0] got;
        drive(o, ax, ay, ai, bx, by, bi, ca);
        run(tag, got);
        check(tag, got, model(o, ax, ay, ai, bx, by, bi, ca));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [16:0] got, hold;
        logic [7:0]  ax, ay, bx, by, ca;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7 reset state
        check("R7 reset", {r_inf, r_x, r_y}, {1'b1, 16'h0000});
        check("R7 reset done", {16'h0, done}, 17'h0);

        // Directed corners
        op_check("R1 add basic", 1'b0, 8'h03, 8'h57, 1'b0, 8'h1C, 8'hA2, 1'b0, 8'h01);
        op_check("R2 dbl basic", 1'b1, 8'h05, 8'h9E, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00);
        op_check("R2 dbl x=1",   1'b1, 8'h01, 8'hFF, 1'b0, 8'h00, 8'h00, 1'b0, 8'h7B);
        op_check("R3 add same",  1'b0, 8'h6D, 8'h21, 1'b0, 8'h6D, 8'h21, 1'b0, 8'h33);
        drive(1'b0, 8'h6D, 8'h21, 1'b0, 8'h00, 8'h00, 1'b0, 8'h33);
        drive(1'b1, 8'h6D, 8'h21, 1'b0, 8'h00, 8'h00, 1'b0, 8'h33);
        run("R3 dbl ref", hold);
        drive(1'b0, 8'h6D, 8'h21, 1'b0, 8'h6D, 8'h21, 1'b0, 8'h33);
        run("R3 add ref", got);
        check("R3 add equals dbl", got, hold);
        op_check("R4 negative",  1'b0, 8'h4A, 8'h10, 1'b0, 8'h4A, 8'h5A, 1'b0, 8'h02);
        op_check("R4 same x",    1'b0, 8'h4A, 8'h10, 1'b0, 8'h4A, 8'h99, 1'b0, 8'h02);
        op_check("R4 x0 pair",   1'b0, 8'h00, 8'h37, 1'b0, 8'h00, 8'h37, 1'b0, 8'h02);
        op_check("R5 P inf",     1'b0, 8'h11, 8'h22, 1'b1, 8'hC3, 8'h5E, 1'b0, 8'h09);
        op_check("R5 Q inf",     1'b0, 8'h11, 8'h22, 1'b0, 8'hC3, 8'h5E, 1'b1, 8'h09);
        op_check("R5 both inf",  1'b0, 8'h11, 8'h22, 1'b1, 8'hC3, 8'h5E, 1'b1, 8'h09);
        op_check("R6 dbl x0",    1'b1, 8'h00, 8'h44, 1'b0, 8'h00, 8'h00, 1'b0, 8'h01);
        op_check("R6 dbl inf",   1'b1, 8'h80, 8'h44, 1'b1, 8'h00, 8'h00, 1'b0, 8'h01);
        check("R7 inf code", {r_inf, r_x, r_y}, {1'b1, 16'h0000});

        // R8: result held through a long idle stretch
        op_check("R1 add pre-hold", 1'b0, 8'hB7, 8'h0E, 1'b0, 8'h29, 8'hD4, 1'b0, 8'h00);
        hold = {r_inf, r_x, r_y};
        drive(1'b0, 8'h00, 8'h00, 1'b1, 8'h00, 8'h00, 1'b0, 8'h00);
        repeat (40) @(negedge clk);
        check("R8 hold", {r_inf, r_x, r_y}, hold);

        // R9: second start mid-operation is ignored
        begin
            int n = 0;
            int dones = 0;
            drive(1'b0, 8'h5C, 8'h13, 1'b0, 8'hE1, 8'h70, 1'b0, 8'h06);
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            repeat (5) @(negedge clk);
            drive(1'b1, 8'h00, 8'h00, 1'b1, 8'h00, 8'h00, 1'b1, 8'h00);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
            while (!done && n < 2000) begin @(negedge clk); n++; end
            check("R9 first result", {r_inf, r_x, r_y},
                  model(1'b0, 8'h5C, 8'h13, 1'b0, 8'hE1, 8'h70, 1'b0, 8'h06));
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (done) dones++;
            end
            check("R9 no extra done", 17'(dones), 17'h0);
        end

        // Constrained random mix
        for (int i = 0; i < 250; i++) begin
            int sel = $urandom % 16;
            ax = 8'($urandom); ay = 8'($urandom);
            bx = 8'($urandom); by = 8'($urandom);
            ca = 8'($urandom);
            if (sel < 6) begin
                if (bx == ax) bx = ax ^ 8'h01;
                op_check("R1 rand add", 1'b0, ax, ay, 1'b0, bx, by, 1'b0, ca);
            end else if (sel < 11) begin
                if (ax == 8'h00) ax = 8'h01;
                op_check("R2 rand dbl", 1'b1, ax, ay, 1'b0, bx, by, 1'b0, ca);
            end else if (sel == 11) begin
                op_check("R3 rand same", 1'b0, ax, ay, 1'b0, ax, ay, 1'b0, ca);
            end else if (sel == 12) begin
                op_check("R4 rand neg", 1'b0, ax, ay, 1'b0, ax, ax ^ ay, 1'b0, ca);
            end else if (sel == 13) begin
                op_check("R5 rand ident", 1'b0, ax, ay, sel[0] ^ ax[0], bx, by, !(sel[0] ^ ax[0]), ca);
            end else begin
                op_check("R6 rand dbl zero", 1'b1, 8'h00, ay, ax[0], bx, by, 1'b0, ca);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule